// File: doc/BRIEF.md
# AIS Burst Frame Encoder

The block takes a complete payload from a transmit byte FIFO and turns it into the line bit stream of one AIS burst before any of it is sent. A load strobe supplies the payload length in bits. The encoder then fetches exactly that many bytes. It emits a 24-bit alternating training pattern and an opening flag. It follows with the bit-stuffed payload, sent LSB first, and the stuffed, complemented frame check sequence. A closing flag and a short run of zero padding bits end the frame. Every bit of this raw stream passes through an NRZI stage, and the resulting line levels are written into an internal bit buffer.

A transmit request may arrive at any time after a valid load. If the frame is not yet complete, the request is held until it is. Playout then advances one buffered level per bit-clock enable, so the transmitter can never run out of data. A done strobe marks the end of the burst. A length that is not a whole number of bytes, or that is larger than the buffer was sized for, is refused with an error flag.

Top module: `ais_burst_encoder`

## Requirements
- R1: The raw stream, before NRZI, is built in this order: 24 training bits alternating 0,1,0,1,... (starting with 0), the flag 0x7E, the stuffed payload, the stuffed check sequence, a second 0x7E flag, and then PAD_BITS (default 4) zero bits.
- R2: A load with length N bits fetches exactly N/8 bytes through `fifo_pop`. Each byte is sent bit 0 first. `fifo_pop` is raised only while `fifo_valid` is high.
- R3: The check sequence uses the bit-serial reflected CCITT polynomial 0x8408, preset to 0xFFFF. It runs over the payload bits in sending order. The register is complemented and sent bit 0 first.
- R4: After five consecutive 1s in the payload or check sequence, a 0 is inserted. The run count continues across the boundary between the two fields, and a stuff bit that falls due after the final check bit is still sent. Training and flag bits are never stuffed.
- R5: NRZI coding: a raw 0 inverts the line level and a raw 1 keeps it. The line level is 0 before the first training bit, and `tx_bit` resets to 0.
- R6: A load whose length has bits [2:0] non-zero, or exceeds MAX_BYTES*8 (1008), sets `cfg_err`. Such a load fetches no byte and builds no frame. The next accepted load clears `cfg_err`.
- R7: A `tx_go` raised while the frame is being built is remembered. Playout (`tx_active`) starts only once `frame_ready` is high.
- R8: During playout, each cycle with `bit_en` high moves the next buffered level onto `tx_bit`. With `bit_en` low, `tx_bit` does not change.
- R9: On the `bit_en` after the last buffered level, `tx_done` pulses for exactly one cycle, and both `tx_active` and `frame_ready` fall.
- R10: `cfg_load` is ignored while a frame is being built, waiting, or sent. `tx_go` is ignored when no frame has been loaded.
- R11: Gaps in `fifo_valid` during the fetch stall the encoder without changing the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Start encoding with length `cfg_bits` |
| cfg_bits | input | CNT_W (10) | Payload length in bits |
| cfg_err | output | 1 | Last load was refused |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | FIFO head byte |
| fifo_pop | output | 1 | Consume FIFO head byte |
| tx_go | input | 1 | Transmit request |
| bit_en | input | 1 | Bit-clock enable |
| frame_ready | output | 1 | Encoded frame held in the buffer |
| tx_active | output | 1 | Playout in progress |
| tx_bit | output | 1 | NRZI line level |
| tx_done | output | 1 | One-cycle end-of-burst strobe |

## Verification
The checker assumes that `fifo_data` is steady while `fifo_valid` is high and unpopped, and that the FIFO only advances on `fifo_pop`. It also assumes `bit_en` is a single-cycle strobe with at least one idle cycle between pulses. The bench FIFO model advances its index only on a sampled pop and gates validity with a cycle counter for the stall case. Its bit-enable task raises `bit_en` for one cycle and then holds it low for one cycle. The frames are checked against a reference stream that the bench builds from the requirements.

// File: rtl/ais_enc_pkg.sv
package ais_enc_pkg;

    localparam int          TRAIN_LEN     = 24;
    localparam int          STUFF_RUN     = 5;
    localparam int          FCS_LEN       = 16;
    localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
    localparam logic [15:0] FCS_PRESET    = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_REFL = 16'h8408;

    typedef enum logic [2:0] {
        BP_IDLE,
        BP_TRAIN,
        BP_SFLAG,
        BP_DATA,
        BP_FCS,
        BP_EFLAG,
        BP_PAD,
        BP_DONE
    } build_phase_e;

    typedef enum logic [1:0] {
        PL_IDLE,
        PL_SEND
    } play_phase_e;

    typedef struct packed {
        logic valid;
        logic value;
    } raw_bit_t;

    function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
        logic        fb;
        logic [15:0] n;
        fb = c[0] ^ b;
        n  = {1'b0, c[15:1]};
        if (fb) n = n ^ FCS_POLY_REFL;
        return n;
    endfunction

    function automatic logic nrzi_next(input logic level, input logic raw);
        return raw ? level : ~level;
    endfunction

endpackage

// File: rtl/ais_enc_fcs.sv
module ais_enc_fcs
    import ais_enc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic        din,
    output logic [15:0] fcs_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) fcs_q <= FCS_PRESET;
        else if (en)      fcs_q <= fcs_step(fcs_q, din);
    end
endmodule

// File: rtl/ais_enc_linebuf.sv
module ais_enc_linebuf
    import ais_enc_pkg::*;
#(
    parameter int   DEPTH      = 1272,
    parameter int   PTR_W      = 11,
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  raw_bit_t         wr,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [PTR_W-1:0] wr_count,
    output logic             rd_level
);
    logic             mem [DEPTH];
    logic             level_q;
    logic             level_n;
    logic             wr_ok;

    assign level_n  = nrzi_next(level_q, wr.value);
    assign wr_ok    = wr.valid && (int'(wr_count) < DEPTH);
    assign rd_level = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            level_q  <= INIT_LEVEL;
            wr_count <= '0;
        end else if (wr_ok) begin
            level_q  <= level_n;
            wr_count <= wr_count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_count] <= level_n;
    end
endmodule

// File: rtl/ais_enc_builder.sv
module ais_enc_builder
    import ais_enc_pkg::*;
#(
    parameter int MAX_BYTES = 126,
    parameter int CNT_W     = 10,
    parameter int PAD_BITS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_bits,
    input  logic             fifo_valid,
    input  logic [7:0]       fifo_data,
    input  logic [15:0]      fcs_q,
    input  logic             release_frame,
    output logic             fifo_pop,
    output logic             cfg_err,
    output logic             fcs_clear,
    output logic             fcs_en,
    output logic             fcs_din,
    output logic             buf_restart,
    output raw_bit_t         raw_out,
    output logic             frame_busy,
    output logic             frame_ready
);
    localparam int         MAX_BITS  = MAX_BYTES * 8;
    localparam logic [7:0] TRAIN_END = 8'(TRAIN_LEN - 1);
    localparam logic [7:0] FCS_END   = 8'(FCS_LEN);
    localparam logic [7:0] PAD_END   = 8'(PAD_BITS - 1);

    build_phase_e     phase;
    logic [7:0]       cnt;
    logic [CNT_W-1:0] bytes_left;
    logic [7:0]       cur_byte;
    logic             byte_ok;
    logic [2:0]       bit_idx;
    logic [2:0]       ones;
    logic             stuff_now;
    logic             accept;
    logic             len_bad;

    assign len_bad     = (cfg_bits[2:0] != 3'd0) || (int'(cfg_bits) > MAX_BITS);
    assign accept      = (phase == BP_IDLE) && cfg_load && !len_bad;
    assign fcs_clear   = accept;
    assign buf_restart = accept;
    assign frame_busy  = (phase != BP_IDLE);
    assign frame_ready = (phase == BP_DONE);
    assign stuff_now   = ((phase == BP_DATA) || (phase == BP_FCS)) && (ones == 3'(STUFF_RUN));
    assign fcs_din     = cur_byte[bit_idx];

    always_comb begin
        raw_out  = '{valid: 1'b0, value: 1'b0};
        fcs_en   = 1'b0;
        fifo_pop = 1'b0;
        unique case (phase)
            BP_TRAIN: raw_out = '{valid: 1'b1, value: cnt[0]};
            BP_SFLAG,
            BP_EFLAG: raw_out = '{valid: 1'b1, value: FLAG_BYTE[cnt[2:0]]};
            BP_DATA: begin
                if (stuff_now) begin
                    raw_out = '{valid: 1'b1, value: 1'b0};
                end else if (byte_ok) begin
                    raw_out = '{valid: 1'b1, value: cur_byte[bit_idx]};
                    fcs_en  = 1'b1;
                end else if (bytes_left != '0) begin
                    fifo_pop = fifo_valid;
                end
            end
            BP_FCS: begin
                if (stuff_now)
                    raw_out = '{valid: 1'b1, value: 1'b0};
                else if (cnt < FCS_END)
                    raw_out = '{valid: 1'b1, value: ~fcs_q[cnt[3:0]]};
            end
            BP_PAD:  raw_out = '{valid: 1'b1, value: 1'b0};
            default: raw_out = '{valid: 1'b0, value: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= BP_IDLE;
            cnt        <= '0;
            bytes_left <= '0;
            cur_byte   <= '0;
            byte_ok    <= 1'b0;
            bit_idx    <= '0;
            ones       <= '0;
            cfg_err    <= 1'b0;
        end else begin
            if ((phase == BP_DATA) || (phase == BP_FCS)) begin
                if (stuff_now)
                    ones <= '0;
                else if (raw_out.valid)
                    ones <= raw_out.value ? ones + 3'd1 : 3'd0;
            end
            unique case (phase)
                BP_IDLE: begin
                    if (cfg_load) begin
                        cfg_err <= len_bad;
                        if (!len_bad) begin
                            bytes_left <= cfg_bits >> 3;
                            cnt        <= '0;
                            byte_ok    <= 1'b0;
                            phase      <= BP_TRAIN;
                        end
                    end
                end
                BP_TRAIN: begin
                    cnt <= cnt + 8'd1;
                    if (cnt == TRAIN_END) begin
                        cnt   <= '0;
                        phase <= BP_SFLAG;
                    end
                end
                BP_SFLAG: begin
                    cnt <= cnt + 8'd1;
                    if (cnt == 8'd7) begin
                        cnt   <= '0;
                        ones  <= '0;
                        phase <= BP_DATA;
                    end
                end
                BP_DATA: begin
                    if (!stuff_now) begin
                        if (byte_ok) begin
                            bit_idx <= bit_idx + 3'd1;
                            if (bit_idx == 3'd7) begin
                                byte_ok    <= 1'b0;
                                bytes_left <= bytes_left - 1'b1;
                            end
                        end else if (fifo_pop) begin
                            cur_byte <= fifo_data;
                            byte_ok  <= 1'b1;
                            bit_idx  <= '0;
                        end else if (bytes_left == '0) begin
                            cnt   <= '0;
                            phase <= BP_FCS;
                        end
                    end
                end
                BP_FCS: begin
                    if (!stuff_now) begin
                        if (cnt == FCS_END) begin
                            cnt   <= '0;
                            phase <= BP_EFLAG;
                        end else begin
                            cnt <= cnt + 8'd1;
                        end
                    end
                end
                BP_EFLAG: begin
                    cnt <= cnt + 8'd1;
                    if (cnt == 8'd7) begin
                        cnt   <= '0;
                        phase <= (PAD_BITS > 0) ? BP_PAD : BP_DONE;
                    end
                end
                BP_PAD: begin
                    cnt <= cnt + 8'd1;
                    if (cnt == PAD_END) begin
                        cnt   <= '0;
                        phase <= BP_DONE;
                    end
                end
                BP_DONE: begin
                    if (release_frame) phase <= BP_IDLE;
                end
                default: phase <= BP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ais_enc_player.sv
module ais_enc_player
    import ais_enc_pkg::*;
#(
    parameter int   PTR_W      = 11,
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_busy,
    input  logic             frame_ready,
    input  logic [PTR_W-1:0] frame_len,
    input  logic             tx_go,
    input  logic             bit_en,
    input  logic             rd_level,
    output logic [PTR_W-1:0] rd_addr,
    output logic             release_frame,
    output logic             tx_active,
    output logic             tx_bit,
    output logic             tx_done
);
    play_phase_e phase;
    logic        go_pend;
    logic        at_end;

    assign at_end        = (rd_addr == frame_len);
    assign release_frame = (phase == PL_SEND) && bit_en && at_end;
    assign tx_active     = (phase == PL_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PL_IDLE;
            go_pend <= 1'b0;
            rd_addr <= '0;
            tx_bit  <= INIT_LEVEL;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            unique case (phase)
                PL_IDLE: begin
                    if (frame_ready && (go_pend || tx_go)) begin
                        phase   <= PL_SEND;
                        go_pend <= 1'b0;
                        rd_addr <= '0;
                    end else if (tx_go && frame_busy) begin
                        go_pend <= 1'b1;
                    end
                end
                PL_SEND: begin
                    if (bit_en) begin
                        if (at_end) begin
                            tx_done <= 1'b1;
                            phase   <= PL_IDLE;
                        end else begin
                            tx_bit  <= rd_level;
                            rd_addr <= rd_addr + 1'b1;
                        end
                    end
                end
                default: phase <= PL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ais_burst_encoder.sv
module ais_burst_encoder
    import ais_enc_pkg::*;
#(
    parameter int   MAX_BYTES  = 126,
    parameter int   PAD_BITS   = 4,
    parameter logic INIT_LEVEL = 1'b0,
    localparam int  MAX_BITS   = MAX_BYTES * 8,
    localparam int  CNT_W      = $clog2(MAX_BITS + 1),
    localparam int  BUF_LEN    = TRAIN_LEN + 16 + MAX_BITS + FCS_LEN
                                 + (MAX_BITS + FCS_LEN) / STUFF_RUN + PAD_BITS,
    localparam int  PTR_W      = $clog2(BUF_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_bits,
    output logic             cfg_err,
    input  logic             fifo_valid,
    input  logic [7:0]       fifo_data,
    output logic             fifo_pop,
    input  logic             tx_go,
    input  logic             bit_en,
    output logic             frame_ready,
    output logic             tx_active,
    output logic             tx_bit,
    output logic             tx_done
);
    logic             fcs_clear;
    logic             fcs_en;
    logic             fcs_din;
    logic [15:0]      fcs_q;
    logic             buf_restart;
    raw_bit_t         raw_bit;
    logic             frame_busy;
    logic             release_frame;
    logic [PTR_W-1:0] rd_addr;
    logic [PTR_W-1:0] frame_len;
    logic             rd_level;

    ais_enc_fcs u_fcs (
        .clk   (clk),
        .rst   (rst),
        .clear (fcs_clear),
        .en    (fcs_en),
        .din   (fcs_din),
        .fcs_q (fcs_q)
    );

    ais_enc_builder #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .PAD_BITS  (PAD_BITS)
    ) u_builder (
        .clk           (clk),
        .rst           (rst),
        .cfg_load      (cfg_load),
        .cfg_bits      (cfg_bits),
        .fifo_valid    (fifo_valid),
        .fifo_data     (fifo_data),
        .fcs_q         (fcs_q),
        .release_frame (release_frame),
        .fifo_pop      (fifo_pop),
        .cfg_err       (cfg_err),
        .fcs_clear     (fcs_clear),
        .fcs_en        (fcs_en),
        .fcs_din       (fcs_din),
        .buf_restart   (buf_restart),
        .raw_out       (raw_bit),
        .frame_busy    (frame_busy),
        .frame_ready   (frame_ready)
    );

    ais_enc_linebuf #(
        .DEPTH      (BUF_LEN),
        .PTR_W      (PTR_W),
        .INIT_LEVEL (INIT_LEVEL)
    ) u_linebuf (
        .clk      (clk),
        .rst      (rst),
        .restart  (buf_restart),
        .wr       (raw_bit),
        .rd_addr  (rd_addr),
        .wr_count (frame_len),
        .rd_level (rd_level)
    );

    ais_enc_player #(
        .PTR_W      (PTR_W),
        .INIT_LEVEL (INIT_LEVEL)
    ) u_player (
        .clk           (clk),
        .rst           (rst),
        .frame_busy    (frame_busy),
        .frame_ready   (frame_ready),
        .frame_len     (frame_len),
        .tx_go         (tx_go),
        .bit_en        (bit_en),
        .rd_level      (rd_level),
        .rd_addr       (rd_addr),
        .release_frame (release_frame),
        .tx_active     (tx_active),
        .tx_bit        (tx_bit),
        .tx_done       (tx_done)
    );
endmodule

// File: rtl/ais_burst_encoder_chk.sv
module ais_burst_encoder_chk (
    input logic clk,
    input logic rst,
    input logic fifo_valid,
    input logic fifo_pop,
    input logic frame_ready,
    input logic tx_active,
    input logic tx_bit,
    input logic bit_en,
    input logic tx_done,
    input logic cfg_err
);
    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_valid && !frame_ready && !tx_active);              // R2

    AST_PLAY_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> frame_ready);                                          // R7

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));                                        // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);                                               // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !tx_active && !frame_ready);                             // R9

    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !frame_ready && !fifo_pop);                              // R6
endmodule

bind ais_burst_encoder ais_burst_encoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_valid  (fifo_valid),
    .fifo_pop    (fifo_pop),
    .frame_ready (frame_ready),
    .tx_active   (tx_active),
    .tx_bit      (tx_bit),
    .bit_en      (bit_en),
    .tx_done     (tx_done),
    .cfg_err     (cfg_err)
);

// File: tb/tb_ais_burst_encoder.sv
module tb_ais_burst_encoder;
    localparam int MAXB  = 126;
    localparam int PADN  = 4;
    localparam int CNT_W = 10;

    // vector: nbytes, seed, mode (bit0 early go, bit1 fifo gaps, bit2 all ones, bit3 extra load)
    localparam logic [23:0] VEC [5] = '{
        {8'd0,   8'h00, 8'h00},
        {8'd1,   8'h00, 8'h04},
        {8'd5,   8'h11, 8'h01},
        {8'd20,  8'hA5, 8'h0A},
        {8'd126, 8'h00, 8'h05}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [CNT_W-1:0] cfg_bits = '0;
    logic cfg_err;
    logic fifo_valid;
    logic [7:0] fifo_data;
    logic fifo_pop;
    logic tx_go = 1'b0;
    logic bit_en = 1'b0;
    logic frame_ready, tx_active, tx_bit, tx_done;

    always #5 clk = ~clk;

    ais_burst_encoder dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bits(cfg_bits),
        .cfg_err(cfg_err), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .tx_go(tx_go), .bit_en(bit_en),
        .frame_ready(frame_ready), .tx_active(tx_active), .tx_bit(tx_bit),
        .tx_done(tx_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] fbytes [256];
    int   favail = 0;
    int   rd_i = 0;
    logic pop_clr = 1'b0;
    logic gaps = 1'b0;
    logic [1:0] cyc = '0;

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        if (pop_clr) rd_i <= 0;
        else if (fifo_pop) rd_i <= rd_i + 1;
    end
    assign fifo_valid = (rd_i < favail) && !(gaps && cyc == 2'b01);
    assign fifo_data  = fbytes[rd_i[7:0]];

    int ebits [1400];
    int elen;
    int raw_q [1400];
    int rlen;
    int ones;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic push_raw(input int b);
        raw_q[rlen] = b;
        rlen++;
    endtask

    task automatic push_stuffed(input int b);
        push_raw(b);
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin
            push_raw(0);
            ones = 0;
        end
    endtask

    task automatic build_expect(input int n);
        logic [15:0] c;
        logic fb;
        int lvl;
        rlen = 0;
        ones = 0;
        c = 16'hFFFF;
        for (int i = 0; i < 24; i++) push_raw(i % 2);
        for (int i = 0; i < 8; i++) push_raw((8'h7E >> i) & 1);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ fbytes[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
                push_stuffed(int'(fbytes[k][i]));
            end
        c = ~c;
        for (int i = 0; i < 16; i++) push_stuffed(int'(c[i]));
        for (int i = 0; i < 8; i++) push_raw((8'h7E >> i) & 1);
        for (int i = 0; i < PADN; i++) push_raw(0);
        lvl = 0;
        for (int i = 0; i < rlen; i++) begin
            if (raw_q[i] == 0) lvl = 1 - lvl;
            ebits[i] = lvl;
        end
        elen = rlen;
    endtask

    task automatic pulse_bit();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    task automatic clear_pops();
        @(negedge clk) pop_clr = 1'b1;
        @(negedge clk) pop_clr = 1'b0;
    endtask

    task automatic run_frame(input int n, input logic [7:0] seed, input logic [7:0] mode);
        int mism, first_i, first_a, guard, held;
        bit early_seen_active;
        for (int k = 0; k < n; k++)
            fbytes[k] = mode[2] ? 8'hFF : 8'(seed + 8'(k * 37));
        build_expect(n);
        favail = n;
        gaps = mode[1];
        clear_pops();
        @(negedge clk) begin cfg_bits = CNT_W'(n * 8); cfg_load = 1'b1; end
        @(negedge clk) begin
            cfg_load = 1'b0;
            if (mode[0]) tx_go = 1'b1;
        end
        chk(cfg_err == 1'b0, "R6 err cleared by good load", int'(cfg_err), 0);
        @(negedge clk) tx_go = 1'b0;
        early_seen_active = 1'b0;
        guard = 0;
        while (!frame_ready && guard < 6000) begin
            if (tx_active) early_seen_active = 1'b1;
            @(negedge clk);
            guard++;
        end
        chk(!early_seen_active && !tx_active, "R7 no playout before ready", int'(tx_active), 0);
        chk(rd_i == n, "R2 R11 byte fetch count", rd_i, n);
        if (mode[3]) begin
            favail = n + 4;
            @(negedge clk) begin cfg_bits = 10'd16; cfg_load = 1'b1; end
            @(negedge clk) cfg_load = 1'b0;
            repeat (8) @(negedge clk);
            chk(rd_i == n, "R10 load ignored while frame held", rd_i, n);
        end
        if (!mode[0]) begin
            @(negedge clk) tx_go = 1'b1;
        end
        @(negedge clk) tx_go = 1'b0;
        chk(tx_active == 1'b1, "R7 playout starts", int'(tx_active), 1);
        mism = 0; first_i = -1; first_a = 0;
        for (int i = 0; i < elen; i++) begin
            pulse_bit();
            if (int'(tx_bit) != ebits[i]) begin
                if (first_i < 0) begin first_i = i; first_a = int'(tx_bit); end
                mism++;
            end
            if (i == 0) begin
                held = int'(tx_bit);
                repeat (3) @(negedge clk);
                chk(int'(tx_bit) == held, "R8 line held without bit_en", int'(tx_bit), held);
            end
        end
        chk(mism == 0, "R1 R3 R4 R5 line stream", first_a,
            (first_i < 0) ? 0 : ebits[first_i]);
        chk(tx_done == 1'b0 && tx_active == 1'b1, "R1 frame length not short", int'(tx_done), 0);
        pulse_bit();
        chk(tx_done == 1'b1 && tx_active == 1'b0 && frame_ready == 1'b0,
            "R9 done after last bit", int'(tx_done), 1);
        @(negedge clk);
        chk(tx_done == 1'b0, "R9 done single cycle", int'(tx_done), 0);
        favail = 0;
        gaps = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_bit == 1'b0, "R5 reset line level", int'(tx_bit), 0);
        chk(!tx_active && !frame_ready && !tx_done && !cfg_err && !fifo_pop,
            "R9 reset outputs idle", int'(tx_active), 0);

        // R10: go with no frame loaded
        @(negedge clk) tx_go = 1'b1;
        @(negedge clk) tx_go = 1'b0;
        repeat (4) @(negedge clk);
        chk(tx_active == 1'b0, "R10 go without frame ignored", int'(tx_active), 0);

        // R6: length not a byte multiple, then too long
        favail = 8;
        for (int k = 0; k < 8; k++) fbytes[k] = 8'h55;
        clear_pops();
        @(negedge clk) begin cfg_bits = 10'd12; cfg_load = 1'b1; end
        @(negedge clk) cfg_load = 1'b0;
        repeat (20) @(negedge clk);
        chk(cfg_err == 1'b1, "R6 odd length flagged", int'(cfg_err), 1);
        chk(rd_i == 0 && !frame_ready, "R6 odd length no fetch", rd_i, 0);
        @(negedge clk) begin cfg_bits = 10'(MAXB * 8 + 8); cfg_load = 1'b1; end
        @(negedge clk) cfg_load = 1'b0;
        repeat (20) @(negedge clk);
        chk(cfg_err == 1'b1, "R6 overlong flagged", int'(cfg_err), 1);
        chk(rd_i == 0 && !frame_ready, "R6 overlong no fetch", rd_i, 0);
        favail = 0;

        foreach (VEC[v])
            run_frame(int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0]);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule